// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external controller read and write a bank of byte-wide configuration registers over a three-signal serial link plus a read/write select. The controller pulls the active-low select low, then clocks an 8-bit address and 8 data bits over one shared data line, most significant bit first. On a write the slave samples all 16 bits. On a read the slave takes the line over right after the address and shifts out the addressed register.

The serial clock, select, direction and data inputs are oversampled by the system clock through two-flop synchronisers. The whole frame engine and the register bank therefore run in the system clock domain. Written values appear on a flat configuration bus that the rest of the chip uses directly. Read-only entries report values taken from a flat status input. The serial clock must run well below the system clock so that every level is seen.

Top module: `ser_regport`

## Requirements
- R1: A frame is 8 address bits followed by 8 data bits, each sampled on a rising serial clock edge, MSB first. A write frame updates the addressed read/write register once the sixteenth bit has been sampled.
- R2: The register index is address bits [7:1]. Address bit 0 has no effect on either reads or writes.
- R3: The direction input is sampled at the eighth address bit. High selects a read and low selects a write.
- R4: On a read, the data MSB appears on `sd_out` within 3 system clocks of the eighth rising serial clock edge. Each of the next 7 rising edges presents the next lower bit.
- R5: Indices 0 to 79 (addresses 0x00 to 0x9F) are read/write and reset to 0x00. Indices 80 to 95 (addresses 0xA0 to 0xBF) are read-only: a read returns `stat_in[8*i+7:8*i]`, a write is ignored, and their `cfg_out` slices stay 0x00.
- R6: Indices 96 to 127 (addresses 0xC0 to 0xFF) are unmapped. Reads return 0x00 and writes change nothing.
- R7: Deselecting (`cs_n` high) clears the frame state. A frame cut short before its sixteenth bit changes no register, and the next frame starts again at the first address bit.
- R8: `sd_oe` is high only during the data phase of a read while selected. It is low throughout the address phase and goes low within 3 system clocks after `cs_n` rises.
- R9: While `rst` is high, all read/write registers are cleared, `sd_oe` and `sd_out` are low, and serial traffic is ignored.
- R10: `cfg_out[8*i+7:8*i]` holds the value of register i. It changes only in the cycle after a completed write frame to a mapped read/write index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the controller |
| cs_n | input | 1 | Active-low select; high clears the frame |
| rd_sel | input | 1 | Direction: 1 read, 0 write |
| sd_in | input | 1 | Serial data line, input side |
| sd_out | output | 1 | Serial data line, output side |
| sd_oe | output | 1 | Output enable for the serial data line |
| stat_in | input | 768 | Read-only register values, 8 bits per index |
| cfg_out | output | 768 | Read/write register values, 8 bits per index |

## Verification
The assertions rely on every level of `sclk`, `cs_n`, `rd_sel` and `sd_in` being held for at least two system clocks. They also rely on `sd_in` and `rd_sel` changing only while `sclk` is low, so that a synchronised rising edge always sees settled data. The bench meets these conditions by holding every serial clock phase for four system clocks. It changes data and select only in the low phase or while deselected. Random frames, truncated frames and writes to read-only and unmapped indices all use this same timing.

// File: rtl/rp_pkg.sv
package rp_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int NUM_REG = 96;
endpackage

// File: rtl/rp_sync.sv
module rp_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rp_frame.sv
module rp_frame #(
  parameter int AW = rp_pkg::ADDR_W,
  parameter int DW = rp_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_s,
  input  logic          csn_s,
  input  logic          rdsel_s,
  input  logic          sdi_s,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          sdo,
  output logic          oe
);
  localparam int FULL = AW + DW;
  localparam int CW = $clog2(FULL + 1);
  localparam logic [CW-1:0] C_LAST_A = CW'(AW - 1);
  localparam logic [CW-1:0] C_AW = CW'(AW);
  localparam logic [CW-1:0] C_LAST = CW'(FULL - 1);
  localparam logic [CW-1:0] C_FULL = CW'(FULL);

  logic          sclk_q;
  logic          rise;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_sh;
  logic [DW-1:0] dat_sh;
  logic [DW-1:0] tx;
  logic          is_rd;

  assign rise    = sclk_s & ~sclk_q;
  assign rd_addr = {addr_sh[AW-2:0], sdi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      cnt     <= '0;
      addr_sh <= '0;
      dat_sh  <= '0;
      tx      <= '0;
      is_rd   <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      sdo     <= 1'b0;
      oe      <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      wr_en  <= 1'b0;
      if (csn_s) begin
        cnt   <= '0;
        is_rd <= 1'b0;
        oe    <= 1'b0;
        sdo   <= 1'b0;
      end else if (rise && cnt != C_FULL) begin
        cnt <= cnt + 1'b1;
        if (cnt < C_AW) begin
          addr_sh <= {addr_sh[AW-2:0], sdi_s};
          if (cnt == C_LAST_A) begin
            is_rd <= rdsel_s;
            if (rdsel_s) begin
              tx  <= rd_data;
              sdo <= rd_data[DW-1];
              oe  <= 1'b1;
            end
          end
        end else if (is_rd) begin
          tx  <= {tx[DW-2:0], 1'b0};
          sdo <= tx[DW-2];
        end else begin
          dat_sh <= {dat_sh[DW-2:0], sdi_s};
          if (cnt == C_LAST) begin
            wr_en   <= 1'b1;
            wr_addr <= addr_sh;
            wr_data <= {dat_sh[DW-2:0], sdi_s};
          end
        end
      end
    end
  end

  // R8: deselect releases the data line on the next cycle
  assert_oe_release_R8: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> !oe);
  // R4/R8: the line is only taken over once the address is complete
  assert_oe_after_addr_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> (cnt == C_AW));
  // R1: a write pulse only ends a complete write frame
  assert_write_full_R1: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (cnt == C_FULL && !is_rd && !oe));
  // R7: the bit counter never runs past the frame length
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= C_FULL);
endmodule

// File: rtl/rp_bank.sv
module rp_bank #(
  parameter int NREG = rp_pkg::NUM_REG,
  parameter int AW = rp_pkg::ADDR_W,
  parameter int DW = rp_pkg::DATA_W,
  parameter logic [NREG-1:0] RO_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic [NREG*DW-1:0] stat_in,
  output logic [NREG*DW-1:0] cfg_out
);
  localparam int IW = AW - 1;

  logic [DW-1:0] regs [NREG];
  logic [IW-1:0] widx;
  logic [IW-1:0] ridx;
  logic          wr_ok;

  assign widx = wr_addr[AW-1:1];
  assign ridx = rd_addr[AW-1:1];

  always_comb begin
    wr_ok = 1'b0;
    if (int'(widx) < NREG) wr_ok = !RO_MASK[int'(widx)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en && wr_ok) begin
      regs[int'(widx)] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(ridx) < NREG) begin
      if (RO_MASK[int'(ridx)]) rd_data = stat_in[int'(ridx)*DW +: DW];
      else                     rd_data = regs[int'(ridx)];
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_cfg
    if (RO_MASK[g]) begin : g_ro
      assign cfg_out[g*DW +: DW] = '0;
    end else begin : g_rw
      assign cfg_out[g*DW +: DW] = regs[g];
    end
  end

  // R10: the configuration bus moves only after a write pulse
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(cfg_out));
  // R5/R6: writes to read-only or unmapped indices leave the bus untouched
  assert_no_ro_write_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_ok) |=> $stable(cfg_out));
endmodule

// File: rtl/ser_regport.sv
module ser_regport #(
  parameter int NREG = rp_pkg::NUM_REG,
  parameter int AW = rp_pkg::ADDR_W,
  parameter int DW = rp_pkg::DATA_W,
  parameter logic [NREG-1:0] RO_MASK = {16'hFFFF, 80'h0}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              rd_sel,
  input  logic              sd_in,
  output logic              sd_out,
  output logic              sd_oe,
  input  logic [NREG*DW-1:0] stat_in,
  output logic [NREG*DW-1:0] cfg_out
);
  logic [3:0]    sync_q;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  rp_sync #(.W(4), .RST_VAL(4'b0100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sclk, cs_n, rd_sel, sd_in}),
    .q   (sync_q)
  );

  rp_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .sclk_s  (sync_q[3]),
    .csn_s   (sync_q[2]),
    .rdsel_s (sync_q[1]),
    .sdi_s   (sync_q[0]),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .sdo     (sd_out),
    .oe      (sd_oe)
  );

  rp_bank #(.NREG(NREG), .AW(AW), .DW(DW), .RO_MASK(RO_MASK)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .stat_in (stat_in),
    .cfg_out (cfg_out)
  );
endmodule

// File: tb/ser_regport_tb.sv
module ser_regport_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic rd_sel = 1'b0;
  logic sd_in = 1'b0;
  logic sd_out, sd_oe;
  logic [767:0] stat_in;
  logic [767:0] cfg_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] model [128];

  always #4 clk = ~clk;

  ser_regport u_dut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .rd_sel(rd_sel),
    .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe),
    .stat_in(stat_in), .cfg_out(cfg_out)
  );

  function automatic logic [7:0] stat_fn(int i);
    return 8'((i * 37 + 5) | 1);
  endfunction

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    int idx = int'(a[7:1]);
    if (idx < 80) return model[idx];
    if (idx < 96) return stat_fn(idx);
    return 8'h00;
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic chk_cfg(string req);
    bit ok = 1'b1;
    logic [7:0] a = 8'h00, e = 8'h00;
    for (int i = 0; i < 96; i++) begin
      logic [7:0] ev = (i < 80) ? model[i] : 8'h00;
      if (cfg_out[i*8 +: 8] !== ev && ok) begin
        ok = 1'b0; a = cfg_out[i*8 +: 8]; e = ev;
      end
    end
    chk(ok, req, a, e);
  endtask

  task automatic xfer(input logic [7:0] a, input bit rd, input logic [7:0] wd,
                      input int nb, output logic [7:0] rdat, output bit oe_ok);
    rdat = '0;
    oe_ok = 1'b1;
    rd_sel = rd;
    cs_n = 1'b0;
    tick(4);
    for (int i = 0; i < nb; i++) begin
      sd_in = (i < 8) ? a[7-i] : (rd ? 1'($urandom % 2) : wd[15-i]);
      tick(4);
      sclk = 1'b1;
      tick(4);
      if (i < 7 && sd_oe !== 1'b0) oe_ok = 1'b0;
      if (rd && i >= 7 && i < 15) begin
        rdat[14-i] = sd_out;
        if (sd_oe !== 1'b1) oe_ok = 1'b0;
      end
      if (!rd && sd_oe !== 1'b0) oe_ok = 1'b0;
      sclk = 1'b0;
    end
    tick(4);
    cs_n = 1'b1;
    tick(5);
    if (sd_oe !== 1'b0) oe_ok = 1'b0;
    if (!rd && nb == 16 && a[7:1] < 7'd80) model[a[7:1]] = wd;
  endtask

  task automatic do_read(logic [7:0] a, string req);
    logic [7:0] r;
    bit ok;
    xfer(a, 1'b1, 8'h00, 16, r, ok);
    chk(r === exp_rd(a), req, r, exp_rd(a));
    chk(ok, "R8 output enable window", {7'd0, ok}, 8'h01);
  endtask

  task automatic do_write(logic [7:0] a, logic [7:0] d, int nb);
    logic [7:0] r;
    bit ok;
    xfer(a, 1'b0, d, nb, r, ok);
    chk(ok, "R8 line released on write", {7'd0, ok}, 8'h01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    bit ok;
    void'($urandom(32'd1234));
    for (int i = 0; i < 96; i++) stat_in[i*8 +: 8] = stat_fn(i);
    for (int i = 0; i < 128; i++) model[i] = 8'h00;

    // R9: traffic while reset is held is ignored
    tick(3);
    xfer(8'h06, 1'b0, 8'hAA, 16, r, ok);
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    chk(sd_oe === 1'b0 && sd_out === 1'b0, "R9 outputs in reset", {6'd0, sd_oe, sd_out}, 8'h00);
    rst = 1'b0;
    tick(6);
    chk_cfg("R9 registers cleared after reset");

    // R1: basic write and readback
    do_write(8'h10, 8'h5A, 16);
    chk(cfg_out[8*8 +: 8] === 8'h5A, "R1 write lands on cfg_out", cfg_out[8*8 +: 8], 8'h5A);
    do_read(8'h10, "R1 R4 readback");
    // R2: address bit 0 ignored
    do_write(8'h23, 8'hC3, 16);
    do_read(8'h22, "R2 bit0 ignored on write");
    do_read(8'h23, "R2 bit0 ignored on read");
    // R3: direction selects read vs write; a read leaves the register alone
    do_read(8'h10, "R3 read does not modify");
    chk_cfg("R3 cfg after reads");
    // R5: read-only entries
    do_write(8'hA4, 8'hFF, 16);
    do_read(8'hA4, "R5 read-only returns status");
    do_read(8'hBF, "R5 last read-only index");
    chk_cfg("R5 read-only write ignored");
    // R6: unmapped entries
    do_write(8'hC4, 8'h77, 16);
    do_read(8'hC4, "R6 unmapped reads zero");
    do_read(8'hFF, "R6 top address reads zero");
    chk_cfg("R6 unmapped write ignored");
    // R7: truncated write frames change nothing and do not desync the next frame
    do_write(8'h30, 8'h99, 12);
    chk_cfg("R7 truncated write discarded");
    do_write(8'h30, 8'h99, 5);
    do_read(8'h30, "R7 frame restarts after deselect");
    // R5: boundary read/write indices
    do_write(8'h00, 8'h81, 16);
    do_write(8'h9F, 8'h7E, 16);
    do_read(8'h00, "R5 first read/write index");
    do_read(8'h9E, "R5 last read/write index");
    chk_cfg("R10 cfg_out matches written values");

    // Random traffic (R1 R4 R10)
    for (int n = 0; n < 120; n++) begin
      logic [7:0] a = 8'($urandom);
      logic [7:0] d = 8'($urandom);
      if ($urandom % 2) do_read(a, "R4 random read");
      else do_write(a, d, ($urandom % 8 == 0) ? 8 + int'($urandom % 8) : 16);
    end
    chk_cfg("R10 cfg_out after random traffic");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule